// File: doc/BRIEF.md
# Edge-Cause GPIO Bank

This block is a memory-mapped general-purpose I/O bank of up to 32 pins. Software controls pin direction and output level through two separate windows, a set window and a clear window. A one written to a bit in the set window turns the matching state bit on, and a one in the clear window turns it off. A zero leaves the bit as it is. The pin levels are brought into the clock domain through a two-flop synchronizer and can be read back. Each pin can detect rising edges, falling edges, or both.

A qualifying edge latches a sticky cause bit. Causes are gated by a per-pin event-enable mask. Software reads the pending causes already masked and acknowledges them by writing ones. A single level interrupt output is high while any enabled cause is pending.

The register port is a 32-bit word-addressed write port with a two-bit region select. The read data is combinational. Region codes: 0 = main, 1 = cause, 2 = set window, 3 = clear window. The word index is the byte offset divided by four.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: A write to region 2 sets bits. Word 0 (byte 0x00) acts on output-enable and word 1 (byte 0x04) acts on output-data. Each written 1 sets that bit and each 0 leaves it unchanged. Reading either word in region 2 returns the current register value.
- R2: A write to region 3 clears bits, using the same word layout as R1. Each written 1 clears that bit and each 0 leaves it unchanged. Reading either word in region 3 returns the current register value.
- R3: `pin_oe` and `pin_out` show the output-enable and output-data registers. They change on the clock edge that takes the write.
- R4: In region 0, word 0 (0x00) is the read/write rising-edge enable and word 1 (0x04) is the read/write falling-edge enable. Word 2 (0x08) reads the synchronized input levels. A change on `pin_in` set up before clock edge k reads back after edge k+1.
- R5: A pin whose rise enable is set latches its cause on a 0-to-1 synchronized transition. A pin whose fall enable is set latches it on a 1-to-0 transition. With both enables set, either edge latches it. An input change before edge k shows up as a cause after edge k+2.
- R6: In region 1, word 5 (0x14) is the read/write event-enable mask. Word 0 (0x00) reads the latched causes ANDed with that mask. A cause latches even while its event enable is 0.
- R7: Writing a 1 to a bit of region 1, word 6 (0x18), clears that latched cause, and a 0 has no effect. If a new edge arrives in the same cycle as the clear, the cause stays set.
- R8: `irq` is high exactly while some cause bit is both latched and enabled.
- R9: Reset clears every register and cause, so every pin is an input and `irq` is low.
- R10: With NPINS below 32, the bits at and above NPINS read as zero, never drive outputs, and never raise causes.
- R11: A read of any word not listed above returns zero. A write to any such word changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Region select (0 main, 1 cause, 2 set, 3 clear) |
| bus_addr | input | 3 | Word index inside the region |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Raw pin levels |
| pin_oe | output | 32 | Output-enable per pin |
| pin_out | output | 32 | Output level per pin |
| irq | output | 1 | Shared interrupt, high while an enabled cause is pending |

## Verification
The bench builds two copies of the block from the same stimulus, one with NPINS = 32 and one with NPINS = 24. The full-width copy exercises every mask bit. The 24-pin copy shows that toggling and writing the top byte leaves its reads, outputs and interrupt untouched. An LFSR drives the pins while clear writes are interleaved with them, so an edge and a clear of the same bit land in the same cycle in some of those cycles.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    typedef enum logic [1:0] {
        RGN_MAIN  = 2'd0,
        RGN_CAUSE = 2'd1,
        RGN_SET   = 2'd2,
        RGN_CLR   = 2'd3
    } region_e;

    localparam int AW = 3;

    // word indices (byte offset / 4)
    localparam logic [AW-1:0] W_RISE  = 3'd0;
    localparam logic [AW-1:0] W_FALL  = 3'd1;
    localparam logic [AW-1:0] W_LEVEL = 3'd2;
    localparam logic [AW-1:0] W_PEND  = 3'd0;
    localparam logic [AW-1:0] W_EVEN  = 3'd5;
    localparam logic [AW-1:0] W_ACK   = 3'd6;
    localparam logic [AW-1:0] W_OE    = 3'd0;
    localparam logic [AW-1:0] W_DATA  = 3'd1;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/gpio_set_clr_reg.sv
module gpio_set_clr_reg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (set_wr) q <= (q | bits) & MASK;
        else if (clr_wr) q <= q & ~bits;
    end
endmodule

// File: rtl/gpio_cause_latch.sv
module gpio_cause_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         ack_wr,
    input  logic [W-1:0] ack_bits,
    output logic [W-1:0] cause_q
);
    logic [W-1:0] hit;
    logic [W-1:0] ack;

    assign hit = (rise & rise_en) | (fall & fall_en);
    assign ack = ack_wr ? ack_bits : '0;

    // a fresh edge outranks a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~ack) | hit;
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_sel,
    input  logic [2:0]    bus_addr,
    input  logic          bus_we,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [31:0]   pin_in,
    output logic [31:0]   pin_oe,
    output logic [31:0]   pin_out,
    output logic          irq
);
    localparam logic [DW-1:0] PIN_MASK = DW'((64'd1 << NPINS) - 64'd1);

    region_e      rgn;
    logic [DW-1:0] wbits;
    logic [DW-1:0] level, rise, fall;
    logic [DW-1:0] rise_en_q, fall_en_q, ev_en_q, cause_q;
    logic [DW-1:0] oe_q, data_q;

    assign rgn   = region_e'(bus_sel);
    assign wbits = bus_wdata & PIN_MASK;

    gpio_in_sync #(.W(DW), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in & PIN_MASK),
        .level(level), .rise(rise), .fall(fall)
    );

    gpio_set_clr_reg #(.W(DW), .MASK(PIN_MASK)) u_oe (
        .clk(clk), .rst_n(rst_n),
        .set_wr(bus_we && rgn == RGN_SET && bus_addr == W_OE),
        .clr_wr(bus_we && rgn == RGN_CLR && bus_addr == W_OE),
        .bits(wbits), .q(oe_q)
    );

    gpio_set_clr_reg #(.W(DW), .MASK(PIN_MASK)) u_data (
        .clk(clk), .rst_n(rst_n),
        .set_wr(bus_we && rgn == RGN_SET && bus_addr == W_DATA),
        .clr_wr(bus_we && rgn == RGN_CLR && bus_addr == W_DATA),
        .bits(wbits), .q(data_q)
    );

    gpio_cause_latch #(.W(DW)) u_cause (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .rise_en(rise_en_q), .fall_en(fall_en_q),
        .ack_wr(bus_we && rgn == RGN_CAUSE && bus_addr == W_ACK),
        .ack_bits(wbits), .cause_q(cause_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
            ev_en_q   <= '0;
        end else if (bus_we) begin
            if (rgn == RGN_MAIN && bus_addr == W_RISE)  rise_en_q <= wbits;
            if (rgn == RGN_MAIN && bus_addr == W_FALL)  fall_en_q <= wbits;
            if (rgn == RGN_CAUSE && bus_addr == W_EVEN) ev_en_q   <= wbits;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rgn)
            RGN_MAIN: begin
                if (bus_addr == W_RISE)       bus_rdata = rise_en_q;
                else if (bus_addr == W_FALL)  bus_rdata = fall_en_q;
                else if (bus_addr == W_LEVEL) bus_rdata = level;
            end
            RGN_CAUSE: begin
                if (bus_addr == W_PEND)      bus_rdata = cause_q & ev_en_q;
                else if (bus_addr == W_EVEN) bus_rdata = ev_en_q;
            end
            RGN_SET, RGN_CLR: begin
                if (bus_addr == W_OE)        bus_rdata = oe_q;
                else if (bus_addr == W_DATA) bus_rdata = data_q;
            end
        endcase
    end

    assign pin_oe  = oe_q;
    assign pin_out = data_q;
    assign irq     = |(cause_q & ev_en_q);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int NPINS = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_sel,
    input logic [2:0]  bus_addr,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic [31:0] pin_oe,
    input logic [31:0] pin_out,
    input logic        irq,
    input logic [31:0] cause_q,
    input logic [31:0] ev_en_q
);
    localparam logic [31:0] MSK = 32'((64'd1 << NPINS) - 64'd1);

    a_r1_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel == 2'd2 && bus_addr == 3'd0)
        |=> ((pin_oe & $past(bus_wdata & MSK)) == $past(bus_wdata & MSK)));

    a_r2_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel == 2'd3 && bus_addr == 3'd1)
        |=> ((pin_out & $past(bus_wdata)) == 32'd0));

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_sel[1]) |=> ($stable(pin_oe) && $stable(pin_out)));

    a_r7_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_sel == 2'd1 && bus_addr == 3'd6)
        |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_en_q != 32'd0));

    a_r10_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_out | cause_q) & ~MSK) == 32'd0);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq(irq), .cause_q(cause_q), .ev_en_q(ev_en_q)
);

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;
    localparam logic [31:0] M24 = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rd_a, oe_a, out_a, rd_b, oe_b, out_b;
    logic        irq_a, irq_b;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    gpio_edge_ctrl #(.NPINS(32)) u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
        .pin_in(pin_in), .pin_oe(oe_a), .pin_out(out_a), .irq(irq_a));

    gpio_edge_ctrl #(.NPINS(24)) u_gpio_edge_ctrl_24 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .pin_in(pin_in), .pin_oe(oe_b), .pin_out(out_b), .irq(irq_b));

    // behavioural reference model (full 32-pin view)
    logic [31:0] m_s1, m_s2, m_s3, m_oe, m_od, m_re, m_fe, m_en, m_c;

    always @(posedge clk) begin
        logic [31:0] edges;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_oe = 0; m_od = 0;
            m_re = 0; m_fe = 0; m_en = 0; m_c = 0;
        end else begin
            edges = (m_re & m_s2 & ~m_s3) | (m_fe & ~m_s2 & m_s3);
            if (bus_we && bus_sel == 2'd1 && bus_addr == 3'd6) m_c = m_c & ~bus_wdata;
            m_c = m_c | edges;
            if (bus_we) begin
                case ({bus_sel, bus_addr})
                    {2'd0, 3'd0}: m_re = bus_wdata;
                    {2'd0, 3'd1}: m_fe = bus_wdata;
                    {2'd1, 3'd5}: m_en = bus_wdata;
                    {2'd2, 3'd0}: m_oe = m_oe | bus_wdata;
                    {2'd2, 3'd1}: m_od = m_od | bus_wdata;
                    {2'd3, 3'd0}: m_oe = m_oe & ~bus_wdata;
                    {2'd3, 3'd1}: m_od = m_od & ~bus_wdata;
                    default: ;
                endcase
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] model_read();
        case ({bus_sel, bus_addr})
            {2'd0, 3'd0}: return m_re;
            {2'd0, 3'd1}: return m_fe;
            {2'd0, 3'd2}: return m_s2;
            {2'd1, 3'd0}: return m_c & m_en;
            {2'd1, 3'd5}: return m_en;
            {2'd2, 3'd0}, {2'd3, 3'd0}: return m_oe;
            {2'd2, 3'd1}, {2'd3, 3'd1}: return m_od;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag();
        if (!rst_n) return "R9 reset";
        case ({bus_sel, bus_addr})
            {2'd0, 3'd0}, {2'd0, 3'd1}, {2'd0, 3'd2}: return "R4 main";
            {2'd1, 3'd0}: return "R5 R6 R7 pending";
            {2'd1, 3'd5}: return "R6 enable";
            {2'd2, 3'd0}, {2'd2, 3'd1}: return "R1 set window";
            {2'd3, 3'd0}, {2'd3, 3'd1}: return "R2 clear window";
            default: return "R11 unmapped";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        cycles++;
        chk(read_tag(), rd_a, model_read());
        chk(rst_n ? "R3 pin_oe" : "R9 pin_oe", oe_a, m_oe);
        chk(rst_n ? "R3 pin_out" : "R9 pin_out", out_a, m_od);
        chk(rst_n ? "R8 irq" : "R9 irq", {31'd0, irq_a}, {31'd0, |(m_c & m_en)});
        chk("R10 read 24-pin", rd_b, model_read() & M24);
        chk("R10 pin_oe 24-pin", oe_b, m_oe & M24);
        chk("R10 pin_out 24-pin", out_b, m_od & M24);
        chk("R10 irq 24-pin", {31'd0, irq_b}, {31'd0, |(m_c & m_en & M24)});
    end

    task automatic wr(input logic [1:0] s, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = s; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic look(input logic [1:0] s, input logic [2:0] a);
        @(negedge clk);
        bus_sel = s; bus_addr = a;
    endtask

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2468;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // walk every word after reset
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 8; a++) look(2'(s), 3'(a));
        wr(2'd2, 3'd0, 32'hF0F0_00FF);
        wr(2'd2, 3'd1, 32'h1234_5678);
        wr(2'd2, 3'd0, 32'h0000_0000);
        wr(2'd3, 3'd0, 32'h0000_000F);
        wr(2'd3, 3'd1, 32'hFFFF_0000);
        wr(2'd3, 3'd1, 32'h0000_0000);
        wr(2'd0, 3'd3, 32'hFFFF_FFFF);
        wr(2'd1, 3'd7, 32'hFFFF_FFFF);
        wr(2'd0, 3'd0, 32'hF000_00FF);
        wr(2'd0, 3'd1, 32'hF000_FF00);
        for (int a = 0; a < 8; a++) look(2'd0, 3'(a));
        // causes latch before enabling
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            pin_in = ~pin_in;
        end
        look(2'd1, 3'd0);
        wr(2'd1, 3'd5, 32'h0F0F_0F0F);
        look(2'd1, 3'd0);
        wr(2'd1, 3'd5, 32'hFFFF_FFFF);
        look(2'd1, 3'd0);
        wr(2'd1, 3'd6, 32'h0000_0000);
        wr(2'd1, 3'd6, 32'h0000_00F0);
        look(2'd1, 3'd0);
        // mixed traffic: edges colliding with acknowledges
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(negedge clk);
            pin_in = pin_in ^ (lfsr & 32'h8421_8421);
            bus_sel = lfsr[9:8];
            bus_addr = lfsr[12:10];
            bus_wdata = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            bus_we = (lfsr[4:2] == 3'd0) || (lfsr[4:2] == 3'd5 && bus_sel == 2'd1);
            if (i % 7 == 0) begin bus_sel = 2'd1; bus_addr = 3'd6; bus_we = 1'b1; end
        end
        @(negedge clk);
        bus_we = 1'b0;
        wr(2'd1, 3'd6, 32'hFFFF_FFFF);
        look(2'd1, 3'd0);
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule